// File: doc/BRIEF.md
# Bus-Idle Automatic Power-Down Controller

This block watches the address strobe of a multiplexed microcontroller bus and puts the surrounding peripheral into a low-power state when the bus has gone quiet. A free-running input clock drives an idle counter. The counter advances on every cycle in which the synchronized strobe is low and clears whenever the strobe is seen high. When fifteen consecutive idle samples have been counted, the controller enters its sleep state. In that state it requests standby from the memories, isolates the microcontroller address/data bus from the internal memories and logic arrays, and sets a per-class drive mode for each port group.

The controller leaves sleep when the strobe starts pulsing again, when the active-low chip-select input falls, or when reset is applied and then released. A block-mask input chooses which microcontroller control lines, and whether the common clock enable, are withheld from the logic arrays while asleep. The idle counter always runs from the raw input clock, so masking the clock never stops the controller from counting or waking. Clearing the enable input forces normal operation at once.

The controller is a three-state machine. `ST_OFF` means disarmed. `ST_COUNT` means armed and counting idle cycles. `ST_SLEEP` means powered down. The transitions are: arm (`ST_OFF` to `ST_COUNT` when enable is high), sleep (`ST_COUNT` to `ST_SLEEP` when the fifteenth idle sample is counted), wake (`ST_SLEEP` to `ST_COUNT` on a strobe rise or chip-select fall), and disarm (any state to `ST_OFF` when enable is low).

Top module: `apd_ctrl`

## Requirements
- R1: While `apd_en` is low, `pd_active` is low and no sleep state is entered. Clearing `apd_en` while asleep drops `pd_active` in the same cycle. After `apd_en` is set with the strobe low, `pd_active` rises on the 16th clock edge.
- R2: `addr_strobe` is active high and passes through a two-flop synchronizer. Once it goes low and stays low, `pd_active` rises on the 17th rising clock edge: two synchronizer stages plus fifteen idle counts.
- R3: Any high synchronized strobe sample clears the idle count, and the count saturates at the threshold. Sleep is entered only if the strobe stays low for at least fifteen full clock periods.
- R4: While asleep, a strobe rising edge wakes the controller. `pd_active` falls on the 3rd clock edge after the strobe rises.
- R5: While asleep, a high-to-low transition of the active-low `cs_n` wakes the controller on the 3rd edge. A `cs_n` level held low, or a rise of `cs_n`, does not wake it.
- R6: An active-low `rst_n` clears the controller to the disarmed state at once, so `pd_active` goes low. After release with the enable set and the strobe low, `pd_active` rises on the 16th edge.
- R7: `mem_standby` and `bus_isolate` are high exactly while `pd_active` is high.
- R8: `ctrl_gated[i]` equals `ctrl_in[i]`, except that it is forced low when `pd_active` is high and `block_mask[i+1]` is set.
- R9: `logic_clk_en` is low only when `pd_active` is high and `block_mask[0]` is set. With every mask bit set, entry timing and wake are unchanged.
- R10: `port_mode` holds one 2-bit code per class at bits [2i+1:2i]. The class order is general I/O = 0, logic output = 1, address out = 2, data = 3, peripheral I/O = 4. The codes are 00 drive normally, 10 undefined, and 11 high impedance. All classes read 00 when awake. Asleep, classes 0 and 1 read 00, class 2 reads 10, and classes 3 and 4 read 11.
- R11: After a wake, the idle count restarts from zero. With the strobe held low, `pd_active` rises again exactly 15 edges after it fell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running input clock, never gated for the counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| apd_en | input | 1 | Arms the power-down controller |
| addr_strobe | input | 1 | Bus address strobe, active high |
| cs_n | input | 1 | Chip-select input, active low |
| block_mask | input | CTRL_W+1 | Bit 0 withholds the clock enable; bits CTRL_W:1 withhold the control lines |
| ctrl_in | input | CTRL_W | Microcontroller control lines bound for the logic arrays |
| pd_active | output | 1 | Power-down state indicator |
| mem_standby | output | 1 | Standby request to the memories |
| bus_isolate | output | 1 | Blocks the address/data bus from memories and logic |
| ctrl_gated | output | CTRL_W | Control lines after masking |
| logic_clk_en | output | 1 | Clock enable for the logic arrays |
| port_mode | output | 10 | Per-class port drive mode codes |

## Verification
The bench builds the block with its defaults: an idle threshold of 15 and three control lines, giving a four-bit mask. That size makes every combination of mask and control input (128 pairs) reachable both asleep and awake, and each pair is compared against an arithmetically computed gating result. The idle-run length is swept from 1 to 18 cycles, which lands on both sides of the fifteen-cycle threshold. Edge counts from stimulus to `pd_active` changes are measured for every entry path and every wake path.

// File: rtl/apd_pkg.sv
package apd_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_COUNT = 2'd1,
        ST_SLEEP = 2'd2
    } apd_state_e;

    typedef enum logic [1:0] {
        PM_DRIVE = 2'b00,
        PM_SPARE = 2'b01,
        PM_UNDEF = 2'b10,
        PM_HIZ   = 2'b11
    } port_mode_e;

    localparam int PORT_CLASSES = 5;
    localparam int PM_W         = 2;

    // Drive mode of each port class while asleep.
    function automatic port_mode_e sleep_mode(input int cls);
        case (cls)
            2:       return PM_UNDEF;
            3, 4:    return PM_HIZ;
            default: return PM_DRIVE;
        endcase
    endfunction

endpackage

// File: rtl/apd_sync.sv
module apd_sync #(
    parameter int         W       = 1,
    parameter int         STAGES  = 2,
    parameter logic [0:0] RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] pipe [STAGES+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= {W{RST_VAL}};
        else        pipe[0] <= d;
    end

    genvar i;
    generate
        for (i = 1; i <= STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[i] <= {W{RST_VAL}};
                else        pipe[i] <= pipe[i-1];
            end
        end
    endgenerate

    assign q      = pipe[STAGES-1];
    assign q_prev = pipe[STAGES];
endmodule

// File: rtl/apd_idle_cnt.sv
module apd_idle_cnt #(
    parameter int LIMIT = 15,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (clr)        cnt <= '0;
        else if (cnt != TOP) cnt <= cnt + 1'b1;
    end

    assert_cnt_saturates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TOP);

    assert_clear_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0);
endmodule

// File: rtl/apd_fsm.sv
module apd_fsm
    import apd_pkg::*;
#(
    parameter int LIMIT = 15,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          strobe_lvl,
    input  logic          strobe_rise,
    input  logic          cs_fall,
    input  logic [CW-1:0] cnt,
    output apd_state_e    state
);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    apd_state_e state_nx;
    logic       idle_done;
    logic       wake;

    assign idle_done = !strobe_lvl && (cnt == LAST);
    assign wake      = strobe_rise || cs_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:   if (en) state_nx = ST_COUNT;                 // arm
            ST_COUNT: if (!en) state_nx = ST_OFF;                  // disarm
                      else if (idle_done) state_nx = ST_SLEEP;     // sleep
            ST_SLEEP: if (!en) state_nx = ST_OFF;                  // disarm
                      else if (wake) state_nx = ST_COUNT;          // wake
            default:  state_nx = ST_OFF;
        endcase
    end

    assert_disarm_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> state == ST_OFF);

    assert_entry_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_SLEEP) |-> $past(cnt) == LAST);

    assert_strobe_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && en && strobe_rise) |=> state == ST_COUNT);

    assert_cs_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && en && cs_fall) |=> state == ST_COUNT);
endmodule

// File: rtl/apd_outs.sv
module apd_outs
    import apd_pkg::*;
#(
    parameter int CTRL_W = 3
) (
    input  logic                       asleep,
    input  logic                       en,
    input  logic [CTRL_W:0]            block_mask,
    input  logic [CTRL_W-1:0]          ctrl_in,
    output logic                       pd_active,
    output logic                       mem_standby,
    output logic                       bus_isolate,
    output logic [CTRL_W-1:0]          ctrl_gated,
    output logic                       logic_clk_en,
    output logic [PORT_CLASSES*PM_W-1:0] port_mode
);
    logic pd;

    always_comb begin
        pd           = asleep && en;
        pd_active    = pd;
        mem_standby  = pd;
        bus_isolate  = pd;
        logic_clk_en = !(pd && block_mask[0]);
        ctrl_gated   = ctrl_in & ~({CTRL_W{pd}} & block_mask[CTRL_W:1]);
    end

    genvar c;
    generate
        for (c = 0; c < PORT_CLASSES; c++) begin : g_class
            localparam port_mode_e SLEEP_CODE = sleep_mode(c);
            assign port_mode[c*PM_W +: PM_W] = pd ? SLEEP_CODE : PM_DRIVE;
        end
    endgenerate
endmodule

// File: rtl/apd_ctrl.sv
module apd_ctrl
    import apd_pkg::*;
#(
    parameter int IDLE_CYCLES = 15,
    parameter int CTRL_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         apd_en,
    input  logic                         addr_strobe,
    input  logic                         cs_n,
    input  logic [CTRL_W:0]              block_mask,
    input  logic [CTRL_W-1:0]            ctrl_in,
    output logic                         pd_active,
    output logic                         mem_standby,
    output logic                         bus_isolate,
    output logic [CTRL_W-1:0]            ctrl_gated,
    output logic                         logic_clk_en,
    output logic [PORT_CLASSES*PM_W-1:0] port_mode
);
    localparam int CW = $clog2(IDLE_CYCLES + 1);

    logic          strobe_s, strobe_p;
    logic          cs_s, cs_p;
    logic [CW-1:0] idle_cnt;
    logic          cnt_clr;
    apd_state_e    state;

    apd_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_strobe (
        .clk(clk), .rst_n(rst_n), .d(addr_strobe), .q(strobe_s), .q_prev(strobe_p)
    );

    apd_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s), .q_prev(cs_p)
    );

    assign cnt_clr = !apd_en || (state != ST_COUNT) || strobe_s;

    // Counter is clocked by the raw clock; the clock mask never reaches it.
    apd_idle_cnt #(.LIMIT(IDLE_CYCLES), .CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .cnt(idle_cnt)
    );

    apd_fsm #(.LIMIT(IDLE_CYCLES), .CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(apd_en),
        .strobe_lvl(strobe_s), .strobe_rise(strobe_s && !strobe_p),
        .cs_fall(cs_p && !cs_s), .cnt(idle_cnt), .state(state)
    );

    apd_outs #(.CTRL_W(CTRL_W)) u_outs (
        .asleep(state == ST_SLEEP), .en(apd_en), .block_mask(block_mask),
        .ctrl_in(ctrl_in), .pd_active(pd_active), .mem_standby(mem_standby),
        .bus_isolate(bus_isolate), .ctrl_gated(ctrl_gated),
        .logic_clk_en(logic_clk_en), .port_mode(port_mode)
    );

    assert_disabled_awake_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !apd_en |-> !pd_active);

    assert_standby_isolate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pd_active |-> (mem_standby && bus_isolate));

    assert_clock_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !logic_clk_en |-> (pd_active && block_mask[0]));

    assert_restart_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP) |=> idle_cnt == '0);
endmodule

// File: tb/apd_ctrl_bench.sv
`timescale 1ns/1ps
module apd_ctrl_bench;
    localparam int IDLE   = 15;
    localparam int CTRL_W = 3;
    localparam logic [9:0] PM_SLEEP = 10'b11_11_10_00_00;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             apd_en = 1'b0;
    logic             addr_strobe = 1'b1;
    logic             cs_n = 1'b1;
    logic [CTRL_W:0]  block_mask = '0;
    logic [CTRL_W-1:0] ctrl_in = '0;
    logic             pd_active, mem_standby, bus_isolate, logic_clk_en;
    logic [CTRL_W-1:0] ctrl_gated;
    logic [9:0]       port_mode;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    apd_ctrl #(.IDLE_CYCLES(IDLE), .CTRL_W(CTRL_W)) u_apd_ctrl (
        .clk(clk), .rst_n(rst_n), .apd_en(apd_en), .addr_strobe(addr_strobe),
        .cs_n(cs_n), .block_mask(block_mask), .ctrl_in(ctrl_in),
        .pd_active(pd_active), .mem_standby(mem_standby), .bus_isolate(bus_isolate),
        .ctrl_gated(ctrl_gated), .logic_clk_en(logic_clk_en), .port_mode(port_mode)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic edges_until(input logic lvl, input int maxn, output int n);
        n = 0;
        while (pd_active !== lvl && n < maxn) begin
            tick();
            n++;
        end
    endtask

    task automatic check_gating(input string req);
        for (int m = 0; m < 16; m++) begin
            for (int c = 0; c < 8; c++) begin
                block_mask = 4'(m);
                ctrl_in    = 3'(c);
                #1;
                if (pd_active) begin
                    check(ctrl_gated == (3'(c) & ~block_mask[3:1]), req, ctrl_gated,
                          int'(3'(c) & ~block_mask[3:1]));
                    check(logic_clk_en == !block_mask[0], "R9", logic_clk_en, !block_mask[0]);
                end else begin
                    check(ctrl_gated == 3'(c), req, ctrl_gated, c);
                    check(logic_clk_en == 1'b1, "R9", logic_clk_en, 1);
                end
            end
        end
        block_mask = '0;
        ctrl_in    = '0;
    endtask

    initial begin
        int n;
        bit saw;
        #20;
        // R6: reset state
        check(pd_active == 0 && mem_standby == 0 && bus_isolate == 0, "R6", pd_active, 0);
        check(port_mode == 10'd0, "R10", port_mode, 0);
        tick();
        rst_n = 1'b1;
        repeat (5) tick();
        // R1: disabled, strobe low for many cycles, no sleep
        addr_strobe = 1'b0;
        saw = 0;
        repeat (30) begin tick(); if (pd_active) saw = 1; end
        check(!saw, "R1", saw, 0);
        // R8 awake gating sweep
        check_gating("R8");
        addr_strobe = 1'b1;
        apd_en = 1'b1;
        repeat (4) tick();
        // R2: entry timing
        addr_strobe = 1'b0;
        edges_until(1'b1, 40, n);
        check(n == 17, "R2", n, 17);
        // R7 / R10 asleep
        check(mem_standby && bus_isolate, "R7", {mem_standby, bus_isolate}, 3);
        check(port_mode == PM_SLEEP, "R10", port_mode, PM_SLEEP);
        check_gating("R8");
        // R4: strobe wake
        addr_strobe = 1'b1;
        edges_until(1'b0, 20, n);
        check(n == 3, "R4", n, 3);
        check(!mem_standby && !bus_isolate, "R7", {mem_standby, bus_isolate}, 0);
        check(port_mode == 10'd0, "R10", port_mode, 0);
        tick();
        addr_strobe = 1'b0;
        edges_until(1'b1, 40, n);
        check(n == 17, "R2", n, 17);
        // R5 / R11: chip-select wake and count restart
        cs_n = 1'b0;
        edges_until(1'b0, 20, n);
        check(n == 3, "R5", n, 3);
        edges_until(1'b1, 40, n);
        check(n == IDLE, "R11", n, IDLE);
        saw = 0;
        repeat (20) begin tick(); if (!pd_active) saw = 1; end
        check(!saw, "R5 held low", saw, 0);
        cs_n = 1'b1;
        saw = 0;
        repeat (8) begin tick(); if (!pd_active) saw = 1; end
        check(!saw, "R5 rise", saw, 0);
        // R1: clearing enable while asleep
        apd_en = 1'b0;
        #1;
        check(pd_active == 0 && mem_standby == 0, "R1", pd_active, 0);
        saw = 0;
        repeat (30) begin tick(); if (pd_active) saw = 1; end
        check(!saw, "R1", saw, 0);
        apd_en = 1'b1;
        edges_until(1'b1, 40, n);
        check(n == 16, "R1", n, 16);
        // R6: reset while asleep, then release
        rst_n = 1'b0;
        #1;
        check(pd_active == 0 && port_mode == 10'd0, "R6", pd_active, 0);
        tick();
        tick();
        rst_n = 1'b1;
        edges_until(1'b1, 40, n);
        check(n == 16, "R6", n, 16);
        addr_strobe = 1'b1;
        repeat (5) tick();
        // R3: idle-run sweep
        for (int k = 1; k <= 18; k++) begin
            addr_strobe = 1'b0;
            saw = 0;
            repeat (k) begin tick(); if (pd_active) saw = 1; end
            addr_strobe = 1'b1;
            repeat (4) begin tick(); if (pd_active) saw = 1; end
            check(saw == (k >= IDLE), "R3", saw, (k >= IDLE));
            repeat (3) tick();
            check(pd_active == 0, "R4", pd_active, 0);
        end
        // R9: all masks set, counter still runs and wakes
        block_mask = '1;
        ctrl_in = '1;
        tick();
        addr_strobe = 1'b0;
        edges_until(1'b1, 40, n);
        check(n == 17, "R9", n, 17);
        check(logic_clk_en == 0 && ctrl_gated == 0, "R9", logic_clk_en, 0);
        addr_strobe = 1'b1;
        edges_until(1'b0, 20, n);
        check(n == 3, "R9", n, 3);
        check(logic_clk_en == 1 && ctrl_gated == '1, "R8", ctrl_gated, 7);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule